// File: doc/BRIEF.md
# Instruction Word Breakpoint Matcher

This block watches the instruction words fetched by each hardware thread of an eight-thread core. It flags a hit when a word agrees with a programmed pattern on the instruction-format fields that software has chosen. Two configuration registers hold the pattern and the per-field enables. Each register is shared by a group of four threads, and bit 2 of the thread ID picks the group. From the field enables the block builds a 32-bit compare mask. A word hits when its masked bits equal the masked pattern.

Software programs a group through a write port tagged with a thread ID and reads back the programmed value through the same ID. Every thread presents its fetched word with a valid flag on its own compare lane and gets a single hit bit back in the same cycle. A global enable bit gates all hits of a group. Without it, an all-clear enable set (an empty mask) would match every word.

Top module: `iwbp_matcher`

## Requirements
- R1: After reset, both group registers read as zero and no thread reports a hit, whatever its word and valid flag.
- R2: A configuration word has the global enable at bit 39, seven field enables at bits 38:32 (bit 32 register-source-2, 33 address-space, 34 immediate-select, 35 register-source-1, 36 opcode-3, 37 destination, 38 major opcode) and the raw pattern at bits 31:0. A write is visible on the following clock. The read port returns the last written word unchanged, including pattern bits outside the mask.
- R3: Thread ID bit 2 selects the group: IDs 0 to 3 address group 0 and IDs 4 to 7 address group 1. A write to one group leaves the other group's readback and hits unchanged.
- R4: The field enables open these mask bits: register-source-2 4:0, address-space 12:5, immediate-select 13, register-source-1 18:14, opcode-3 24:19, destination 29:25, major opcode 31:30.
- R5: A lane hits exactly when its valid flag is high, its group's global enable is set, and (word AND mask) equals (pattern AND mask).
- R6: With the global enable set and all field enables clear, every valid word hits.
- R7: With the global enable clear, no lane of that group hits.
- R8: A lane whose valid flag is low never hits.
- R9: One write changes the compare behaviour of all four threads of the addressed group alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tid | input | 3 | Thread ID for write and read; bit 2 picks the group |
| cfg_wdata | input | 40 | Configuration word to write |
| cfg_rdata | output | 40 | Configuration word of the group selected by cfg_tid |
| cmp_valid | input | 8 | Per-thread fetched-word valid |
| cmp_instr | input | 256 | Per-thread 32-bit words, thread t at bits 32t+31:32t |
| cmp_hit | output | 8 | Per-thread breakpoint hit |

## Verification
A stored mask that disagrees with the enables shows up as a wrong hit on the very next word that differs from the pattern in an affected field. The field-by-field vectors therefore reach each field's mask bits one at a time. A write landing in the wrong group shows at once in the other group's readback and in hits on its four lanes. Because hits are combinational from state, every fault is visible in the cycle after the write that causes it. A write that takes effect too early shows in the readback taken before the capturing edge.

// File: rtl/iwbp_pkg.sv
package iwbp_pkg;

    localparam int IW_W       = 32;
    localparam int NUM_FIELDS = 7;

    // Configuration word: global enable, field enables, raw pattern.
    typedef struct packed {
        logic                  gen;
        logic [NUM_FIELDS-1:0] fen;
        logic [IW_W-1:0]       pat;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Field order follows the enable bit order in the configuration word.
    function automatic int field_lsb(input int f);
        case (f)
            0:       return 0;   // register source 2
            1:       return 5;   // address space
            2:       return 13;  // immediate select
            3:       return 14;  // register source 1
            4:       return 19;  // opcode 3
            5:       return 25;  // destination
            default: return 30;  // major opcode
        endcase
    endfunction

    function automatic int field_width(input int f);
        case (f)
            0:       return 5;
            1:       return 8;
            2:       return 1;
            3:       return 5;
            4:       return 6;
            5:       return 5;
            default: return 2;
        endcase
    endfunction

    function automatic logic [IW_W-1:0] build_mask(input logic [NUM_FIELDS-1:0] fen);
        logic [IW_W-1:0] m;
        m = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (fen[f]) begin
                m = m | (((IW_W'(1) << field_width(f)) - IW_W'(1)) << field_lsb(f));
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/iwbp_cfg_bank.sv
module iwbp_cfg_bank
    import iwbp_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GRP_W      = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [GRP_W-1:0]                 wgrp_i,
    input  cfg_t                             wdata_i,
    input  logic [GRP_W-1:0]                 rgrp_i,
    output cfg_t                             rdata_o,
    output logic [NUM_GROUPS-1:0][IW_W-1:0]  mask_o,
    output logic [NUM_GROUPS-1:0][IW_W-1:0]  data_o,
    output logic [NUM_GROUPS-1:0]            gen_o
);

    typedef struct packed {
        cfg_t [NUM_GROUPS-1:0]            cfg;
        logic [NUM_GROUPS-1:0][IW_W-1:0]  mask;
        logic [NUM_GROUPS-1:0][IW_W-1:0]  data;
    } bank_t;

    bank_t           st_d, st_q;
    logic [IW_W-1:0] wmask;

    assign wmask = build_mask(wdata_i.fen);

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cfg[wgrp_i]  = wdata_i;
            st_d.mask[wgrp_i] = wmask;
            st_d.data[wgrp_i] = wdata_i.pat & wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.cfg[rgrp_i];
    assign mask_o  = st_q.mask;
    assign data_o  = st_q.data;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gen
        assign gen_o[g] = st_q.cfg[g].gen;

        // R3: a write aimed at another group leaves this one untouched
        a_r3_other_group_kept : assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && (wgrp_i != GRP_W'(g))) |=> $stable(st_q.cfg[g]));
    end

    // R1: reset clears all state
    a_r1_reset_clear : assert property (@(posedge clk)
        !rst_n |=> (st_q == '0));

    // R2: a write is held from the next clock
    a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (st_q.cfg[$past(wgrp_i)] == $past(wdata_i)));

endmodule

// File: rtl/iwbp_lane_cmp.sv
module iwbp_lane_cmp
    import iwbp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [IW_W-1:0] instr_i,
    input  logic [IW_W-1:0] mask_i,
    input  logic [IW_W-1:0] data_i,
    input  logic            gen_i,
    output logic            hit_o
);

    logic match;

    assign match = ((instr_i & mask_i) == data_i);
    assign hit_o = valid_i & gen_i & match;

    // R7: a group with its global enable off never hits
    a_r7_gen_off_no_hit : assert property (@(posedge clk) disable iff (!rst_n)
        !gen_i |-> !hit_o);

    // R8: an idle lane never hits
    a_r8_idle_no_hit : assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !hit_o);

endmodule

// File: rtl/iwbp_matcher.sv
module iwbp_matcher
    import iwbp_pkg::*;
#(
    parameter int NUM_THREADS       = 8,
    parameter int THREADS_PER_GROUP = 4,
    parameter int TID_W             = $clog2(NUM_THREADS),
    parameter int CFG_BITS          = iwbp_pkg::CFG_W,
    parameter int INSTR_W           = iwbp_pkg::IW_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [TID_W-1:0]               cfg_tid,
    input  logic [CFG_BITS-1:0]            cfg_wdata,
    output logic [CFG_BITS-1:0]            cfg_rdata,
    input  logic [NUM_THREADS-1:0]         cmp_valid,
    input  logic [NUM_THREADS*INSTR_W-1:0] cmp_instr,
    output logic [NUM_THREADS-1:0]         cmp_hit
);

    localparam int NUM_GROUPS = NUM_THREADS / THREADS_PER_GROUP;
    localparam int TPG_W      = $clog2(THREADS_PER_GROUP);
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    logic [GRP_W-1:0]                 grp_sel;
    cfg_t                             rd_cfg;
    logic [NUM_GROUPS-1:0][IW_W-1:0]  grp_mask;
    logic [NUM_GROUPS-1:0][IW_W-1:0]  grp_data;
    logic [NUM_GROUPS-1:0]            grp_gen;

    assign grp_sel = cfg_tid[TPG_W +: GRP_W];

    iwbp_cfg_bank #(
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wgrp_i  (grp_sel),
        .wdata_i (cfg_t'(cfg_wdata)),
        .rgrp_i  (grp_sel),
        .rdata_o (rd_cfg),
        .mask_o  (grp_mask),
        .data_o  (grp_data),
        .gen_o   (grp_gen)
    );

    assign cfg_rdata = rd_cfg;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
        localparam int GRP  = t / THREADS_PER_GROUP;
        localparam int LEAD = GRP * THREADS_PER_GROUP;

        iwbp_lane_cmp u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (cmp_valid[t]),
            .instr_i (cmp_instr[t*INSTR_W +: INSTR_W]),
            .mask_i  (grp_mask[GRP]),
            .data_i  (grp_data[GRP]),
            .gen_i   (grp_gen[GRP]),
            .hit_o   (cmp_hit[t])
        );

        if (t != LEAD) begin : g_share
            // R9: threads of one group given the same word agree on the hit
            a_r9_group_share : assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_valid[t] && cmp_valid[LEAD] &&
                 (cmp_instr[t*INSTR_W +: INSTR_W] == cmp_instr[LEAD*INSTR_W +: INSTR_W]))
                |-> (cmp_hit[t] == cmp_hit[LEAD]));
        end
    end

endmodule

// File: tb/iwbp_matcher_tb.sv
module iwbp_matcher_tb_top;

    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_tid = '0;
    logic [39:0]   cfg_wdata = '0;
    logic [39:0]   cfg_rdata;
    logic [NT-1:0] cmp_valid = '0;
    logic [NT*32-1:0] cmp_instr = '0;
    logic [NT-1:0] cmp_hit;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    iwbp_matcher dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_tid   (cfg_tid),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmp_valid (cmp_valid),
        .cmp_instr (cmp_instr),
        .cmp_hit   (cmp_hit)
    );

    // Control byte: bit 7 global enable, bits 6:0 field enables
    // (0 rs2, 1 asi, 2 imm, 3 rs1, 4 op3, 5 rd, 6 op).
    localparam int NV = 12;
    localparam logic [7:0]  V_CTL [NV] = '{8'h81, 8'h81, 8'h82, 8'h84, 8'h88, 8'h90,
                                           8'hA0, 8'hC0, 8'hFF, 8'hFF, 8'h80, 8'h7F};
    localparam logic [31:0] V_PAT [NV] = '{32'h0000_0011, 32'h0000_0011, 32'h0000_0AA0,
                                           32'h0000_2000, 32'h0007_C000, 32'h01F8_0000,
                                           32'h0A00_0000, 32'hC000_0000, 32'hDEAD_BEEF,
                                           32'hDEAD_BEEF, 32'h0000_1234, 32'h1357_9BDF};
    localparam logic [31:0] V_INS [NV] = '{32'hFFFF_FFF1, 32'h0000_0012, 32'h1234_2AA7,
                                           32'h0000_0000, 32'h0007_C000, 32'h01F0_0000,
                                           32'h0AFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF,
                                           32'hDEAD_BEEE, 32'hFFFF_FFFF, 32'h1357_9BDF};
    localparam logic        V_EXP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    task automatic check(input logic cond, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] tid, input logic [39:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_tid   = tid;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
        #1;
    endtask

    task automatic set_lane(input int t, input logic v, input logic [31:0] w);
        cmp_valid[t] = v;
        cmp_instr[t*32 +: 32] = w;
    endtask

    initial begin : watchdog
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        cfg_tid = 3'd0;
        #1;
        check(cfg_rdata == '0, "R1 group0 readback", 64'(cfg_rdata), 0);
        cfg_tid = 3'd4;
        #1;
        check(cfg_rdata == '0, "R1 group1 readback", 64'(cfg_rdata), 0);
        for (int t = 0; t < NT; t++) set_lane(t, 1'b1, 32'h0);
        #1;
        check(cmp_hit == '0, "R1 no hit after reset", 64'(cmp_hit), 0);
        cmp_valid = '0;

        // R4/R5/R6/R7 vector table on group 0, thread 2
        for (int i = 0; i < NV; i++) begin
            write_cfg(3'd1, {V_CTL[i], V_PAT[i]});
            set_lane(2, 1'b1, V_INS[i]);
            #1;
            check(cmp_hit[2] == V_EXP[i], $sformatf("R4/R5/R6/R7 vector %0d", i),
                  64'(cmp_hit[2]), 64'(V_EXP[i]));
        end
        cmp_valid = '0;

        // R2: readback returns the raw pattern, not the masked one
        write_cfg(3'd3, {8'h81, 32'hCAFE_F00D});
        cfg_tid = 3'd0;
        #1;
        check(cfg_rdata == {8'h81, 32'hCAFE_F00D}, "R2 raw readback",
              64'(cfg_rdata), 64'({8'h81, 32'hCAFE_F00D}));

        // R2: a write is not visible before the capturing edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_tid = 3'd0; cfg_wdata = {8'h80, 32'h1111_1111};
        #1;
        check(cfg_rdata == {8'h81, 32'hCAFE_F00D}, "R2 old value before edge",
              64'(cfg_rdata), 64'({8'h81, 32'hCAFE_F00D}));
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(cfg_rdata == {8'h80, 32'h1111_1111}, "R2 new value after edge",
              64'(cfg_rdata), 64'({8'h80, 32'h1111_1111}));

        // R3: program group 1 via thread 6, group 0 unchanged
        write_cfg(3'd6, {8'hFF, 32'hA5A5_5A5A});
        cfg_tid = 3'd2;
        #1;
        check(cfg_rdata == {8'h80, 32'h1111_1111}, "R3 group0 kept",
              64'(cfg_rdata), 64'({8'h80, 32'h1111_1111}));
        cfg_tid = 3'd5;
        #1;
        check(cfg_rdata == {8'hFF, 32'hA5A5_5A5A}, "R3 group1 readback via tid5",
              64'(cfg_rdata), 64'({8'hFF, 32'hA5A5_5A5A}));

        // R9: all four group-1 threads hit on the exact word
        for (int t = 0; t < NT; t++) set_lane(t, 1'b1, 32'hA5A5_5A5A);
        #1;
        // group 0 has empty mask + gen: all hit too (R6)
        check(cmp_hit == 8'hFF, "R9 all group1 lanes hit (group0 empty mask R6)",
              64'(cmp_hit), 64'hFF);
        // R3: disable group 0, group 1 still hits
        write_cfg(3'd0, {8'h00, 32'h0});
        check(cmp_hit == 8'hF0, "R3 only group1 hits", 64'(cmp_hit), 64'hF0);
        // R9: a mismatching word misses on every group-1 lane
        for (int t = 4; t < NT; t++) set_lane(t, 1'b1, 32'hA5A5_5A5B);
        #1;
        check(cmp_hit == 8'h00, "R9 group1 lanes miss together", 64'(cmp_hit), 0);

        // R8: valid low suppresses hits
        for (int t = 0; t < NT; t++) set_lane(t, 1'b0, 32'hA5A5_5A5A);
        #1;
        check(cmp_hit == 8'h00, "R8 idle lanes never hit", 64'(cmp_hit), 0);
        set_lane(7, 1'b1, 32'hA5A5_5A5A);
        #1;
        check(cmp_hit == 8'h80, "R8 only valid lane hits", 64'(cmp_hit), 64'h80);

        // R7: clearing global enable of group 1 stops its hits
        write_cfg(3'd7, {8'h7F, 32'hA5A5_5A5A});
        check(cmp_hit == 8'h00, "R7 global enable off", 64'(cmp_hit), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule